// File: doc/BRIEF.md
# Retirement order checker

This block watches the retirement trace of a processor core and checks that the order index of retired instructions behaves sensibly over a bounded observation window. The trace has one or more retirement lanes. Each lane carries a valid bit, a wide order index, a halt flag and the register addresses the instruction read and wrote. The checker is held in reset for some leading stretch of cycles and is then released for a window. Inside that window a single trigger pulse marks the instruction under scrutiny, and a check pulse marks the window's last cycle.

On the trigger cycle the block captures the order index K of the retiring instruction, together with its halt flag and its destination register. From then on it watches for three faults. First, it checks that a successor with index K+1 retires before the check cycle, unless K halted. Second, it checks that no other retirement reuses K. Third, it checks that no older instruction (index below K) retires later and reads the register that K wrote. The three faults are reported on three separate sticky flags. Only a reset clears them.

Top module: `rord_checker`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, all three error outputs are 0.
- R2: The index K is taken on the first cycle where `trig` is high and at least one lane is valid, from the lowest-numbered valid lane. Later trigger pulses have no effect on K.
- R3: If no lane retires index K+1 between the trigger cycle and the cycle before `chk`, `err_live` goes high the cycle after `chk`. A K+1 on another lane in the trigger cycle itself counts as a successor.
- R4: If the captured instruction K had its halt flag set, `err_live` stays low even with no successor.
- R5: A K+1 retirement that arrives on the `chk` cycle itself does not satisfy liveness.
- R6: Any valid retirement carrying index K on a cycle after the trigger raises `err_uniq` on the next cycle, without waiting for `chk`.
- R7: Two or more lanes retiring index K in the trigger cycle count as a duplicate and raise `err_uniq` on the next cycle.
- R8: A valid retirement after the trigger cycle, with index below K, whose first or second source address equals K's nonzero destination address, raises `err_causal` the cycle after `chk`. A destination of register 0 never causes a causality error. Neither does a reader with an index above K.
- R9: A trigger pulse with no valid lane arms nothing, and all three checks then pass.
- R10: Once raised, an error output stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the checker |
| trig | input | 1 | Marks the cycle whose retirement is captured as K |
| chk | input | 1 | Marks the last cycle of the window; liveness and causality are judged here |
| ret_valid | input | NRET | Per-lane retirement valid |
| ret_order | input | NRET*ORDW | Per-lane order index, lane i at bits [i*ORDW +: ORDW] |
| ret_halt | input | NRET | Per-lane halt flag |
| ret_rs1 | input | NRET*5 | Per-lane first source register address |
| ret_rs2 | input | NRET*5 | Per-lane second source register address |
| ret_rd | input | NRET*5 | Per-lane destination register address, 0 means no write |
| err_live | output | 1 | Sticky: no successor of K retired in time |
| err_uniq | output | 1 | Sticky: index K retired more than once |
| err_causal | output | 1 | Sticky: an older instruction read K's result after K retired |

## Verification
The embedded properties assume a few things about the inputs. `chk` is raised at most once per reset period, and it comes on or after the trigger cycle. Register address fields only matter on lanes whose valid bit is set. Each directed scenario starts from its own reset and raises trigger and check exactly once, in that order. The one exception is a deliberate second trigger pulse, which is there to show it is ignored. The stimulus only ever drives the valid, order and register fields together on lanes that are marked valid.

// File: rtl/rord_pkg.sv
// Shared definitions for the retirement order checker.
// Assumes a register file addressed by a 5-bit field, where address 0 is never written.
package rord_pkg;
    localparam int REG_AW = 5;
    typedef logic [REG_AW-1:0] reg_addr_t;
endpackage

// File: rtl/rord_capture.sv
// Captures the order index, halt flag and destination of the instruction
// that retires on the first trigger cycle with any valid lane.
// When several lanes are valid, the lowest-numbered lane wins.
// Presents the reference values combinationally: the lane selection in the
// trigger cycle itself, and the held copy after that.
module rord_capture
    import rord_pkg::*;
#(
    parameter int NRET = 2,
    parameter int ORDW = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   trig_i,
    input  logic [NRET-1:0]        valid_i,
    input  logic [NRET*ORDW-1:0]   order_i,
    input  logic [NRET-1:0]        halt_i,
    input  logic [NRET*REG_AW-1:0] rd_i,
    output logic                   fire_o,
    output logic                   armed_o,
    output logic [ORDW-1:0]        cur_k_o,
    output logic                   cur_halt_o,
    output reg_addr_t              cur_rd_o
);
    logic [ORDW-1:0] sel_order, k_order_q;
    logic            sel_halt, k_halt_q, armed_q;
    reg_addr_t       sel_rd, k_rd_q;

    // Select the lowest-numbered valid lane.
    always_comb begin
        sel_order = '0;
        sel_halt  = 1'b0;
        sel_rd    = '0;
        for (int i = NRET - 1; i >= 0; i--) begin
            if (valid_i[i]) begin
                sel_order = order_i[i*ORDW +: ORDW];
                sel_halt  = halt_i[i];
                sel_rd    = rd_i[i*REG_AW +: REG_AW];
            end
        end
    end

    assign fire_o = trig_i && !armed_q && (|valid_i);

    // Hold the reference instruction once captured.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q   <= 1'b0;
            k_order_q <= '0;
            k_halt_q  <= 1'b0;
            k_rd_q    <= '0;
        end else if (fire_o) begin
            armed_q   <= 1'b1;
            k_order_q <= sel_order;
            k_halt_q  <= sel_halt;
            k_rd_q    <= sel_rd;
        end
    end

    assign armed_o    = armed_q;
    assign cur_k_o    = armed_q ? k_order_q : sel_order;
    assign cur_halt_o = armed_q ? k_halt_q  : sel_halt;
    assign cur_rd_o   = armed_q ? k_rd_q    : sel_rd;

    // R2
    index_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_o |=> (armed_o && $stable(cur_k_o) && $stable(cur_rd_o)));
endmodule

// File: rtl/rord_match.sv
// Per-lane comparators against the reference instruction. For each lane it
// flags an equal index, the successor index, and an older index that reads
// the reference destination register (only when that register is nonzero).
module rord_match
    import rord_pkg::*;
#(
    parameter int NRET = 2,
    parameter int ORDW = 64
) (
    input  logic [NRET-1:0]        valid_i,
    input  logic [NRET*ORDW-1:0]   order_i,
    input  logic [NRET*REG_AW-1:0] rs1_i,
    input  logic [NRET*REG_AW-1:0] rs2_i,
    input  logic [ORDW-1:0]        cur_k_i,
    input  reg_addr_t              cur_rd_i,
    output logic [NRET-1:0]        eq_k_o,
    output logic [NRET-1:0]        eq_next_o,
    output logic [NRET-1:0]        older_rd_o
);
    logic [ORDW-1:0] next_k;
    logic            rd_live;

    assign next_k  = cur_k_i + ORDW'(1);
    assign rd_live = (cur_rd_i != '0);

    for (genvar g = 0; g < NRET; g++) begin : g_lane
        logic [ORDW-1:0] ord;
        reg_addr_t       a1, a2;
        assign ord = order_i[g*ORDW +: ORDW];
        assign a1  = rs1_i[g*REG_AW +: REG_AW];
        assign a2  = rs2_i[g*REG_AW +: REG_AW];
        // Compare one lane against the reference.
        assign eq_k_o[g]     = valid_i[g] && (ord == cur_k_i);
        assign eq_next_o[g]  = valid_i[g] && (ord == next_k);
        assign older_rd_o[g] = valid_i[g] && (ord < cur_k_i) && rd_live
                               && ((a1 == cur_rd_i) || (a2 == cur_rd_i));
    end
endmodule

// File: rtl/rord_flags.sv
// Sticky error flags. Uniqueness is flagged on the cycle after a duplicate.
// Liveness and causality are judged on the check cycle.
// Assumes chk comes at most once per reset period.
module rord_flags #(
    parameter int NRET = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            chk_i,
    input  logic            fire_i,
    input  logic            armed_i,
    input  logic            halt_i,
    input  logic [NRET-1:0] eq_k_i,
    input  logic [NRET-1:0] eq_next_i,
    input  logic [NRET-1:0] older_rd_i,
    output logic            err_live_o,
    output logic            err_uniq_o,
    output logic            err_causal_o
);
    localparam int CW = $clog2(NRET + 1);

    logic          seen_next_q, causal_q, live_q, uniq_q, cz_q;
    logic [CW-1:0] k_cnt;
    logic          dup_hit, live_fail, causal_fail;

    // Count the lanes that carry the reference index this cycle.
    always_comb begin
        k_cnt = '0;
        for (int i = 0; i < NRET; i++) k_cnt = k_cnt + CW'(eq_k_i[i]);
    end

    assign dup_hit     = armed_i ? (|eq_k_i) : (fire_i && (k_cnt > CW'(1)));
    assign live_fail   = chk_i && (fire_i || armed_i) && !halt_i && !seen_next_q;
    assign causal_fail = chk_i && armed_i && (causal_q || (|older_rd_i));

    // Track the successor and older readers seen before the check cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_next_q <= 1'b0;
            causal_q    <= 1'b0;
        end else begin
            if ((fire_i || armed_i) && !chk_i && (|eq_next_i)) seen_next_q <= 1'b1;
            if (armed_i && (|older_rd_i)) causal_q <= 1'b1;
        end
    end

    // Latch the sticky error outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= 1'b0;
            uniq_q <= 1'b0;
            cz_q   <= 1'b0;
        end else begin
            if (live_fail)   live_q <= 1'b1;
            if (dup_hit)     uniq_q <= 1'b1;
            if (causal_fail) cz_q   <= 1'b1;
        end
    end

    assign err_live_o   = live_q;
    assign err_uniq_o   = uniq_q;
    assign err_causal_o = cz_q;

    // R6
    uniq_prompt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_i && (|eq_k_i)) |=> err_uniq_o);
    // R3
    live_at_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_live_o) |-> $past(chk_i));
    // R4
    halt_waive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_i && armed_i && halt_i && !err_live_o) |=> !err_live_o);
    // R8
    causal_at_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_causal_o) |-> $past(chk_i && armed_i));
endmodule

// File: rtl/rord_checker.sv
// Top of the retirement order checker: captures a reference retirement on
// trigger, then reports liveness, uniqueness and causality faults of the
// order index on three sticky outputs. Lane fields are packed lane 0 lowest.
module rord_checker
    import rord_pkg::*;
#(
    parameter int NRET = 2,
    parameter int ORDW = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   trig,
    input  logic                   chk,
    input  logic [NRET-1:0]        ret_valid,
    input  logic [NRET*ORDW-1:0]   ret_order,
    input  logic [NRET-1:0]        ret_halt,
    input  logic [NRET*REG_AW-1:0] ret_rs1,
    input  logic [NRET*REG_AW-1:0] ret_rs2,
    input  logic [NRET*REG_AW-1:0] ret_rd,
    output logic                   err_live,
    output logic                   err_uniq,
    output logic                   err_causal
);
    logic            fire, armed, cur_halt;
    logic [ORDW-1:0] cur_k;
    reg_addr_t       cur_rd;
    logic [NRET-1:0] eq_k, eq_next, older_rd;

    rord_capture #(.NRET(NRET), .ORDW(ORDW)) u_capture (
        .clk(clk), .rst_n(rst_n), .trig_i(trig), .valid_i(ret_valid),
        .order_i(ret_order), .halt_i(ret_halt), .rd_i(ret_rd),
        .fire_o(fire), .armed_o(armed), .cur_k_o(cur_k),
        .cur_halt_o(cur_halt), .cur_rd_o(cur_rd)
    );

    rord_match #(.NRET(NRET), .ORDW(ORDW)) u_match (
        .valid_i(ret_valid), .order_i(ret_order), .rs1_i(ret_rs1),
        .rs2_i(ret_rs2), .cur_k_i(cur_k), .cur_rd_i(cur_rd),
        .eq_k_o(eq_k), .eq_next_o(eq_next), .older_rd_o(older_rd)
    );

    rord_flags #(.NRET(NRET)) u_flags (
        .clk(clk), .rst_n(rst_n), .chk_i(chk), .fire_i(fire),
        .armed_i(armed), .halt_i(cur_halt), .eq_k_i(eq_k),
        .eq_next_i(eq_next), .older_rd_i(older_rd),
        .err_live_o(err_live), .err_uniq_o(err_uniq), .err_causal_o(err_causal)
    );
endmodule

// File: tb/test_rord_checker.sv
// Directed bench for rord_checker: one task per scenario, each checking its own results.
module test_rord_checker;
    localparam int NRET = 2;
    localparam int ORDW = 64;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 trig = 1'b0, chk = 1'b0;
    logic [NRET-1:0]      v = '0, h = '0;
    logic [NRET*ORDW-1:0] ordv = '0;
    logic [NRET*5-1:0]    s1 = '0, s2 = '0, rdv = '0;
    logic                 e_live, e_uniq, e_cz;
    int                   n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    rord_checker #(.NRET(NRET), .ORDW(ORDW)) i_rord_checker (
        .clk(clk), .rst_n(rst_n), .trig(trig), .chk(chk),
        .ret_valid(v), .ret_order(ordv), .ret_halt(h),
        .ret_rs1(s1), .ret_rs2(s2), .ret_rd(rdv),
        .err_live(e_live), .err_uniq(e_uniq), .err_causal(e_cz)
    );

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic idle();
        v = '0; h = '0; trig = 1'b0; chk = 1'b0;
    endtask

    task automatic ret(int ch, longint ord, int rd, int r1, int r2, bit hl);
        v[ch] = 1'b1;
        h[ch] = hl;
        ordv[ch*ORDW +: ORDW] = ord;
        rdv[ch*5 +: 5] = rd[4:0];
        s1[ch*5 +: 5]  = r1[4:0];
        s2[ch*5 +: 5]  = r2[4:0];
    endtask

    task automatic expect_f(bit l, bit u, bit c, string tag);
        n_chk++;
        if ({e_live, e_uniq, e_cz} !== {l, u, c}) begin
            n_fail++;
            $display("FAIL %s: live/uniq/causal=%b%b%b expected %b%b%b",
                     tag, e_live, e_uniq, e_cz, l, u, c);
        end
    endtask

    task automatic do_reset();
        cyc(); idle(); rst_n = 1'b0;
        cyc(); cyc();
        rst_n = 1'b1;
    endtask

    task automatic close_window();
        chk = 1'b1; cyc(); idle();
    endtask

    task automatic t_reset();
        rst_n = 1'b0; cyc();
        expect_f(0, 0, 0, "R1 during reset");
        rst_n = 1'b1; cyc();
        expect_f(0, 0, 0, "R1 after reset");
    endtask

    task automatic t_live_ok();
        do_reset();
        ret(0, 10, 3, 0, 0, 0); trig = 1'b1; cyc(); idle();
        ret(1, 11, 4, 0, 0, 0); cyc(); idle(); cyc();
        close_window();
        expect_f(0, 0, 0, "R3 successor present");
    endtask

    task automatic t_live_same_cycle();
        do_reset();
        ret(0, 8, 0, 0, 0, 0); ret(1, 9, 0, 0, 0, 0); trig = 1'b1; cyc(); idle(); cyc();
        close_window();
        expect_f(0, 0, 0, "R3 successor in trigger cycle");
    endtask

    task automatic t_live_miss();
        do_reset();
        ret(0, 10, 3, 0, 0, 0); trig = 1'b1; cyc(); idle(); cyc(); cyc();
        expect_f(0, 0, 0, "R3 no flag before check");
        close_window();
        expect_f(1, 0, 0, "R3 missing successor");
        cyc(); cyc();
        expect_f(1, 0, 0, "R10 live sticky");
    endtask

    task automatic t_halt();
        do_reset();
        ret(0, 5, 0, 0, 0, 1); trig = 1'b1; cyc(); idle(); cyc();
        close_window();
        expect_f(0, 0, 0, "R4 halt waives liveness");
    endtask

    task automatic t_late_next();
        do_reset();
        ret(0, 5, 0, 0, 0, 0); trig = 1'b1; cyc(); idle(); cyc();
        ret(0, 6, 0, 0, 0, 0); close_window();
        expect_f(1, 0, 0, "R5 successor on check cycle");
    endtask

    task automatic t_capture();
        do_reset();
        ret(1, 20, 0, 0, 0, 0); trig = 1'b1; cyc(); idle();
        ret(0, 99, 0, 0, 0, 0); trig = 1'b1; cyc(); idle();
        ret(0, 21, 0, 0, 0, 0); cyc(); idle();
        close_window();
        expect_f(0, 0, 0, "R2 second trigger ignored");
        do_reset();
        ret(0, 50, 0, 0, 0, 0); ret(1, 60, 0, 0, 0, 0); trig = 1'b1; cyc(); idle();
        ret(1, 51, 0, 0, 0, 0); cyc(); idle();
        close_window();
        expect_f(0, 0, 0, "R2 lowest lane captured");
    endtask

    task automatic t_dup_later();
        do_reset();
        ret(0, 30, 0, 0, 0, 0); trig = 1'b1; cyc(); idle();
        ret(0, 31, 0, 0, 0, 0); cyc(); idle();
        ret(1, 30, 0, 0, 0, 0); cyc(); idle();
        expect_f(0, 1, 0, "R6 duplicate flagged at once");
        cyc(); close_window(); cyc();
        expect_f(0, 1, 0, "R10 uniq sticky");
    endtask

    task automatic t_dup_same();
        do_reset();
        ret(0, 7, 0, 0, 0, 0); ret(1, 7, 0, 0, 0, 0); trig = 1'b1; cyc(); idle();
        expect_f(0, 1, 0, "R7 same-cycle duplicate");
        ret(0, 8, 0, 0, 0, 0); cyc(); idle();
        close_window();
        expect_f(0, 1, 0, "R7 after window");
    endtask

    task automatic t_causal();
        do_reset();
        ret(0, 20, 5, 0, 0, 0); trig = 1'b1; cyc(); idle();
        ret(0, 21, 6, 5, 0, 0); ret(1, 19, 7, 1, 5, 0); cyc(); idle(); cyc();
        expect_f(0, 0, 0, "R8 causal waits for check");
        close_window();
        expect_f(0, 0, 1, "R8 older reader after writer");
        do_reset();
        ret(0, 40, 0, 0, 0, 0); trig = 1'b1; cyc(); idle();
        ret(0, 39, 2, 0, 0, 0); ret(1, 41, 2, 0, 0, 0); cyc(); idle();
        close_window();
        expect_f(0, 0, 0, "R8 register 0 never causal");
    endtask

    task automatic t_vacuous();
        do_reset();
        trig = 1'b1; cyc(); idle();
        ret(0, 3, 0, 0, 0, 0); cyc(); idle();
        close_window();
        expect_f(0, 0, 0, "R9 empty trigger passes");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_live_ok();
        t_live_same_cycle();
        t_live_miss();
        t_halt();
        t_late_next();
        t_capture();
        t_dup_later();
        t_dup_same();
        t_causal();
        t_vacuous();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule